// File: doc/BRIEF.md
# Type B Reader Frame Serializer

This block turns a reader command held in a byte buffer, with its CRC already appended, into the bit stream a proximity-card reader sends on a Type B link. It walks the buffer through a byte-read port. It wraps the characters in the fixed framing the link requires: an idle-high lead-in, a long low start-of-frame run, framed characters, a long low end-of-frame run and an idle-high tail. The tail is long enough for the last character to clear the modulator before the reader turns to receive.

The bit rate is set outside the block. Each pulse on `etu_tick` moves the stream on by one elementary time unit, and the block presents that bit for one clock with `bit_valid`. A one-cycle `done` pulse closes the frame. A `start` strobe with a length begins a frame. While a frame is running, `start` is ignored. CRC generation and the modulator itself sit outside this block.

Top module: `rdr_frame_ser`

## Requirements
- R1: After a synchronous reset, `bit_valid` and `done` are low and `rd_addr` is 0.
- R2: The block emits exactly one bit per `etu_tick` pulse while a frame is active. `bit_valid` is high in the clock after the tick and low otherwise. A tick arriving in the same cycle as an accepted `start` emits nothing.
- R3: A frame opens with LEAD_ONES (default 10) one bits, followed by SOF_ZEROS (11) zero bits.
- R4: After the start-of-frame zeros come GAP_ONES (2) one bits, before the first character.
- R5: Each byte is sent as a character of ten bits: a 0 start bit, then the eight data bits least significant first, then a 1 stop bit. Bytes are fetched in ascending address order from 0 over `rd_addr`. `rd_data` must show the byte at `rd_addr` one clock after the address is presented.
- R6: After the last character comes one single 1 bit, followed by EOF_ZEROS (11) zero bits.
- R7: After the end-of-frame zeros come POST_ONES (8) one bits, then GUARD_ONES (10) guard one bits. A frame of n bytes is therefore 53 + 10·n bits long with the default parameters.
- R8: `done` is high for exactly one clock, in the cycle after the `bit_valid` of the last guard bit.
- R9: A `start` pulse while a frame is in progress has no effect on that frame's bits, its length or its single `done` pulse.
- R10: A length of 0 sends the lead-in, the start-of-frame run and the gap, then goes straight on to the single 1 bit and the end-of-frame run, with no characters (53 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame when the block is idle |
| frame_len | input | LEN_W | Number of bytes in the frame, sampled with `start` |
| etu_tick | input | 1 | One pulse per elementary time unit |
| rd_addr | output | ADDR_W | Address of the buffer byte to read |
| rd_data | input | DATA_W | Buffer byte, one clock after `rd_addr` |
| bit_out | output | 1 | Serial bit, meaningful while `bit_valid` is high |
| bit_valid | output | 1 | High for one clock per emitted bit |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The assertions take for granted that `frame_len` never exceeds MAX_LEN. They also assume that the buffer answers a new `rd_addr` within one clock and keeps its contents unchanged for the life of a frame. The stimulus keeps within these limits. The bench models the buffer as a registered read of a memory that is filled before each `start` and left alone until `done`. It uses only lengths from 0 to 64. Tick patterns include every cycle, fixed spacing and irregular spacing. Extra `start` pulses are placed well inside a running frame.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_LEAD,
    PH_SOF,
    PH_GAP,
    PH_CHAR,
    PH_PRE,
    PH_EOF,
    PH_POST,
    PH_GUARD
  } rfs_phase_e;

  function automatic int rfs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfs_phase_ctrl.sv
module rfs_phase_ctrl
  import rfs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEAD_ONES  = 10,
  parameter int SOF_ZEROS  = 11,
  parameter int GAP_ONES   = 2,
  parameter int PRE_ONES   = 1,
  parameter int EOF_ZEROS  = 11,
  parameter int POST_ONES  = 8,
  parameter int GUARD_ONES = 10,
  parameter int LEN_W      = 7,
  parameter int ADDR_W     = 6,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic [LEN_W-1:0]  frame_len,
  output rfs_phase_e        phase,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              load,
  output logic              last
);

  localparam int CHAR_BITS = DATA_W + 2;

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] byte_idx;
  logic [CNT_W-1:0] run_last;
  rfs_phase_e       phase_nx;
  logic             step;
  logic             at_end;
  logic             final_byte;

  always_comb begin
    case (phase)
      PH_LEAD:  run_last = CNT_W'(LEAD_ONES - 1);
      PH_SOF:   run_last = CNT_W'(SOF_ZEROS - 1);
      PH_GAP:   run_last = CNT_W'(GAP_ONES - 1);
      PH_CHAR:  run_last = CNT_W'(CHAR_BITS - 1);
      PH_PRE:   run_last = CNT_W'(PRE_ONES - 1);
      PH_EOF:   run_last = CNT_W'(EOF_ZEROS - 1);
      PH_POST:  run_last = CNT_W'(POST_ONES - 1);
      PH_GUARD: run_last = CNT_W'(GUARD_ONES - 1);
      default:  run_last = '0;
    endcase
  end

  assign step       = tick && (phase != PH_IDLE);
  assign at_end     = (cnt == run_last);
  assign final_byte = ((byte_idx + LEN_W'(1)) == len_q);
  assign load       = step && (phase == PH_CHAR) && (cnt == '0);
  assign last       = step && (phase == PH_GUARD) && at_end;

  always_comb begin
    case (phase)
      PH_LEAD:  phase_nx = PH_SOF;
      PH_SOF:   phase_nx = PH_GAP;
      PH_GAP:   phase_nx = (len_q == '0) ? PH_PRE : PH_CHAR;
      PH_CHAR:  phase_nx = final_byte ? PH_PRE : PH_CHAR;
      PH_PRE:   phase_nx = PH_EOF;
      PH_EOF:   phase_nx = PH_POST;
      PH_POST:  phase_nx = PH_GUARD;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      len_q    <= '0;
      byte_idx <= '0;
      rd_addr  <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase    <= PH_LEAD;
        cnt      <= '0;
        len_q    <= frame_len;
        byte_idx <= '0;
        rd_addr  <= '0;
      end
    end else if (step) begin
      if (at_end) begin
        phase <= phase_nx;
        cnt   <= '0;
        if (phase == PH_CHAR) byte_idx <= byte_idx + LEN_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      if (load) rd_addr <= rd_addr + ADDR_W'(1);
    end
  end

  // R2: without a tick the position in the frame does not move
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !tick) |=> ($stable(phase) && $stable(cnt)));

  // R9: a start during a frame leaves the captured length alone
  assert_len_held_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && start) |=> $stable(len_q));

  // R5: the read address only advances when a character begins
  assert_addr_on_load_R5: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !load) |=> $stable(rd_addr));

endmodule

// File: rtl/rfs_char_shift.sv
module rfs_char_shift
  import rfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  rfs_phase_e        phase,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              load,
  input  logic [DATA_W-1:0] rd_data,
  output logic              data_bit
);

  logic [DATA_W-1:0] sh;
  logic              shift;

  assign shift = tick && (phase == PH_CHAR) && (cnt != '0) &&
                 (cnt <= CNT_W'(DATA_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (load) begin
      sh <= rd_data;
    end else if (shift) begin
      sh <= sh >> 1;
    end
  end

  assign data_bit = sh[0];

endmodule

// File: rtl/rfs_bit_out.sv
module rfs_bit_out
  import rfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  rfs_phase_e       phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             data_bit,
  input  logic             last,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             done
);

  logic bit_nx;
  logic last_q;

  always_comb begin
    case (phase)
      PH_SOF, PH_EOF: bit_nx = 1'b0;
      PH_CHAR: begin
        if (cnt == '0)                     bit_nx = 1'b0;
        else if (cnt == CNT_W'(DATA_W + 1)) bit_nx = 1'b1;
        else                               bit_nx = data_bit;
      end
      default: bit_nx = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out   <= 1'b1;
      bit_valid <= 1'b0;
      last_q    <= 1'b0;
      done      <= 1'b0;
    end else begin
      bit_valid <= tick && (phase != PH_IDLE);
      if (tick && (phase != PH_IDLE)) bit_out <= bit_nx;
      last_q <= last;
      done   <= last_q;
    end
  end

  // R2: every valid bit is the answer to a tick one clock earlier
  assert_valid_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(tick));

  // R3: start-of-frame bits leave low
  assert_sof_low_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SOF && tick) |=> (bit_valid && !bit_out));

  // R5: the stop bit of each character is high
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CHAR && cnt == CNT_W'(DATA_W + 1) && tick) |=> bit_out);

  // R7: guard bits are high
  assert_guard_high_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GUARD && tick) |=> (bit_valid && bit_out));

  // R8: done lasts a single clock
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/rdr_frame_ser.sv
module rdr_frame_ser
  import rfs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MAX_LEN    = 64,
  parameter int LEAD_ONES  = 10,
  parameter int SOF_ZEROS  = 11,
  parameter int GAP_ONES   = 2,
  parameter int PRE_ONES   = 1,
  parameter int EOF_ZEROS  = 11,
  parameter int POST_ONES  = 8,
  parameter int GUARD_ONES = 10,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int ADDR_W    = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              etu_tick,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              bit_out,
  output logic              bit_valid,
  output logic              done
);

  localparam int MAX_RUN = rfs_max(
    rfs_max(rfs_max(LEAD_ONES, SOF_ZEROS), rfs_max(GAP_ONES, PRE_ONES)),
    rfs_max(rfs_max(EOF_ZEROS, POST_ONES), rfs_max(GUARD_ONES, DATA_W + 2)));
  localparam int CNT_W = $clog2(MAX_RUN + 1);

  rfs_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic             last;
  logic             data_bit;

  rfs_phase_ctrl #(
    .DATA_W(DATA_W), .LEAD_ONES(LEAD_ONES), .SOF_ZEROS(SOF_ZEROS),
    .GAP_ONES(GAP_ONES), .PRE_ONES(PRE_ONES), .EOF_ZEROS(EOF_ZEROS),
    .POST_ONES(POST_ONES), .GUARD_ONES(GUARD_ONES),
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .tick(etu_tick),
    .frame_len(frame_len), .phase(phase), .cnt(cnt),
    .rd_addr(rd_addr), .load(load), .last(last)
  );

  rfs_char_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .tick(etu_tick), .phase(phase), .cnt(cnt),
    .load(load), .rd_data(rd_data), .data_bit(data_bit)
  );

  rfs_bit_out #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .tick(etu_tick), .phase(phase), .cnt(cnt),
    .data_bit(data_bit), .last(last),
    .bit_out(bit_out), .bit_valid(bit_valid), .done(done)
  );

endmodule

// File: tb/tb_rdr_frame_ser.sv
module tb_rdr_frame_ser;
  localparam int DW = 8;
  localparam int ML = 64;
  localparam int LW = $clog2(ML + 1);
  localparam int AW = $clog2(ML);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic bit_out, bit_valid, done;

  always #5 clk = ~clk;

  logic [DW-1:0] mem [ML];
  always @(posedge clk) rd_data <= mem[rd_addr];

  rdr_frame_ser dut (
    .clk(clk), .rst(rst), .start(start), .frame_len(len), .etu_tick(tick),
    .rd_addr(rd_addr), .rd_data(rd_data), .bit_out(bit_out),
    .bit_valid(bit_valid), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int valid_cnt = 0;
  int done_cnt = 0;
  int tick_period = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: a queue of expected bits with requirement tags
  bit    exp_q[$];
  string tag_q[$];
  bit    m_active = 0;
  bit    m_pend = 0;
  bit    e_valid = 0, e_bit = 0, e_done = 0;
  string e_tag = "R2";

  task automatic push_run(input int n, input bit v, input string t);
    for (int i = 0; i < n; i++) begin exp_q.push_back(v); tag_q.push_back(t); end
  endtask

  task automatic build(input int n);
    push_run(10, 1'b1, "R3");
    push_run(11, 1'b0, "R3");
    push_run(2, 1'b1, "R4");
    for (int b = 0; b < n; b++) begin
      push_run(1, 1'b0, "R5");
      for (int k = 0; k < DW; k++) push_run(1, mem[b][k], "R5");
      push_run(1, 1'b1, "R5");
    end
    push_run(1, 1'b1, "R6");
    push_run(11, 1'b0, "R6");
    push_run(8, 1'b1, "R7");
    push_run(10, 1'b1, "R7");
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; m_pend = 0; e_valid = 0; e_done = 0;
      exp_q.delete(); tag_q.delete();
    end else begin
      e_done = m_pend;
      m_pend = 0;
      e_valid = 0;
      if (!m_active) begin
        if (start) begin m_active = 1; build(int'(len)); end
      end else if (tick) begin
        e_valid = 1;
        e_bit = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        if (exp_q.size() == 0) begin m_active = 0; m_pend = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(bit_valid == e_valid, e_valid ? e_tag : "R2", "bit_valid",
          int'(bit_valid), int'(e_valid));
      if (e_valid)
        chk(bit_out == e_bit, e_tag, "bit_out", int'(bit_out), int'(e_bit));
      chk(done == e_done, "R8", "done", int'(done), int'(e_done));
      if (bit_valid) valid_cnt++;
      if (done) done_cnt++;
    end
  end

  // tick generator: period 0 means irregular spacing
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk); #1;
      if (tick_period == 0) tick = ($urandom_range(0, 2) != 0);
      else begin
        ph = (ph + 1 >= tick_period) ? 0 : ph + 1;
        tick = (ph == 0);
      end
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < ML; i++) mem[i] = DW'(i * 37 + seed) ^ 8'h5A;
  endtask

  task automatic run_frame(input int n, input int period, input bit noisy,
                           input string req);
    tick_period = period;
    fill(n * 11 + period);
    @(negedge clk);
    valid_cnt = 0;
    done_cnt = 0;
    @(posedge clk); #1;
    start = 1'b1; len = LW'(n);
    @(posedge clk); #1;
    start = 1'b0;
    if (noisy) begin
      repeat (6) @(posedge clk);
      #1 start = 1'b1; len = LW'(2);
      @(posedge clk); #1 start = 1'b0;
      repeat (20) @(posedge clk);
      #1 start = 1'b1; len = LW'(0);
      @(posedge clk); #1 start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(valid_cnt == 53 + 10 * n, req, "bit count", valid_cnt, 53 + 10 * n);
    chk(done_cnt == 1, req, "done count", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bit_valid == 1'b0, "R1", "bit_valid", int'(bit_valid), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(rd_addr == '0, "R1", "rd_addr", int'(rd_addr), 0);
    run_frame(3, 1, 1'b0, "R7");
    run_frame(1, 4, 1'b0, "R5");
    run_frame(0, 1, 1'b0, "R10");
    run_frame(5, 0, 1'b1, "R9");
    run_frame(64, 1, 1'b0, "R5");
    run_frame(2, 2, 1'b1, "R9");
    run_frame(0, 3, 1'b0, "R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule